// File: doc/BRIEF.md
# Lane Code-Group Synchronization Monitor

This block watches one 8b/10b receive lane after decoding and reports whether the lane holds code-group synchronization. Each clock it takes one decoded code group in the form of three flags: the group is a comma, the group failed to decode, or the group broke running disparity. A group with either error flag set is a bad group, and a group with neither is a good group. The block has no data path. It drives one status bit, and another part of the receiver decides what to do when that bit falls.

Acquisition needs three good commas, each followed by a good code group. Once the lane is synchronized, a 2-bit policy input selects how it loses synchronization. Policy 0 is the standard Ethernet-style hysteresis: each bad group raises an error level, each run of four good groups lowers it by one, and a bad group at the fourth level drops synchronization. Policies 1, 2 and 3 drop synchronization as soon as that many bad groups arrive back to back. The policy can change while traffic is running. The new policy applies from the next code group, and the lane's current state is kept.

Top module: `lane_sync_fsm`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `in_sync` is 0 and the block is waiting for a comma.
- R2: While out of sync, only a good comma starts acquisition. A comma that carries an error flag, and any non-comma group, leave the block waiting for a comma.
- R3: `in_sync` rises in the cycle after the good group that follows the third good comma of an unbroken acquisition. It is still 0 after only two comma/good pairs.
- R4: A bad group at any point during acquisition aborts it. Three fresh comma/good pairs are then needed.
- R5: A decode error (`code_err`) and a disparity error (`disp_err`) have the same effect. Either flag alone makes the group bad.
- R6: With `loss_mode` = 2'b00, the fourth bad group drops `in_sync` when no run of four good groups came between the bad ones, even if fewer than four good groups separate each bad group. Three such bad groups keep `in_sync` at 1.
- R7: With `loss_mode` = 2'b00, each run of four consecutive good groups lowers the error level by one. After 1 bad group and 4 good groups, three more bad groups keep sync and a fourth drops it.
- R8: With `loss_mode` = 2'b01, a single bad group while in sync drops `in_sync` in the next cycle.
- R9: With `loss_mode` = 2'b10, two adjacent bad groups drop sync. A single bad group does not drop sync, and a good group resets the adjacency count.
- R10: With `loss_mode` = 2'b11, three adjacent bad groups drop sync. Two adjacent bad groups followed by a good group do not.
- R11: A change of `loss_mode` applies from the next code group without resetting the state. Adjacent bad groups seen under policy 0 count toward an adjacency policy, and the hysteresis level reached under policy 0 is kept while an adjacency policy is active.
- R12: A good group never drops `in_sync`, whatever the policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Code-group clock, one group per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| is_comma | input | 1 | Current group is a comma character |
| code_err | input | 1 | Current group failed 8b/10b decoding |
| disp_err | input | 1 | Current group violated running disparity |
| loss_mode | input | 2 | Loss policy: 00 hysteresis, 01/10/11 drop after 1/2/3 adjacent bad groups |
| in_sync | output | 1 | Lane is code-group synchronized |

## Verification
The only visible output is `in_sync`, so a wrong error level, good-run count or adjacency count cannot be seen directly. It shows up only as a drop that comes one bad group too early or too late, or as a drop that never happens. The bench therefore uses error patterns that separate neighbouring counts: three against four accumulated bad groups, runs of three against four good groups between bad ones, and adjacency chains broken one group short. A wrong acquisition count shows up as `in_sync` rising one comma pair early or late. Every fault is exposed within at most about ten code groups of the stimulus that triggers it.

// File: rtl/lane_sync_fsm.sv
module lane_sync_fsm #(
  parameter int ACQ_COMMAS  = 3,
  parameter int GOOD_RUN    = 4,
  parameter int HYST_LEVELS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       is_comma,
  input  logic       code_err,
  input  logic       disp_err,
  input  logic [1:0] loss_mode,
  output logic       in_sync
);

  localparam int CW = $clog2(ACQ_COMMAS + 1);
  localparam int GW = (GOOD_RUN > 1) ? $clog2(GOOD_RUN) : 1;
  localparam int LW = (HYST_LEVELS > 1) ? $clog2(HYST_LEVELS) : 1;

  typedef enum logic [1:0] {ST_LOS, ST_COMMA, ST_ACQ, ST_SYNC} st_t;

  st_t          state_q, state_d;
  logic [CW-1:0] commas_q, commas_d;
  logic [GW-1:0] good_q, good_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic [1:0]    adj_q, adj_d;

  logic bad, comma_ok, hyst_mode, adj_hit, at_top, run_done;

  assign bad       = code_err | disp_err;
  assign comma_ok  = is_comma & ~bad;
  assign hyst_mode = (loss_mode == 2'b00);
  assign adj_hit   = ({1'b0, adj_q} + 3'd1) >= {1'b0, loss_mode};
  assign at_top    = (lvl_q == LW'(HYST_LEVELS - 1));
  assign run_done  = (good_q == GW'(GOOD_RUN - 1));
  assign in_sync   = (state_q == ST_SYNC);

  always_comb begin
    state_d  = state_q;
    commas_d = commas_q;
    good_d   = good_q;
    lvl_d    = lvl_q;
    adj_d    = adj_q;
    case (state_q)
      ST_LOS: begin
        if (comma_ok) begin
          state_d  = ST_COMMA;
          commas_d = CW'(1);
        end
      end
      ST_COMMA: begin
        if (bad) begin
          state_d = ST_LOS;
        end else if (commas_q == CW'(ACQ_COMMAS)) begin
          state_d = ST_SYNC;
          good_d  = '0;
          lvl_d   = '0;
          adj_d   = '0;
        end else begin
          state_d = ST_ACQ;
        end
      end
      ST_ACQ: begin
        if (bad) begin
          state_d = ST_LOS;
        end else if (is_comma) begin
          state_d  = ST_COMMA;
          commas_d = commas_q + CW'(1);
        end
      end
      default: begin
        if (bad) begin
          good_d = '0;
          adj_d  = (adj_q == 2'd3) ? 2'd3 : adj_q + 2'd1;
          if (hyst_mode ? at_top : adj_hit)
            state_d = ST_LOS;
          else if (hyst_mode)
            lvl_d = lvl_q + LW'(1);
        end else begin
          adj_d = '0;
          if (lvl_q != '0) begin
            if (run_done) begin
              lvl_d  = lvl_q - LW'(1);
              good_d = '0;
            end else begin
              good_d = good_q + GW'(1);
            end
          end
        end
      end
    endcase
    if (state_d == ST_LOS) begin
      commas_d = '0;
      good_d   = '0;
      lvl_d    = '0;
      adj_d    = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_LOS;
      commas_q <= '0;
      good_q   <= '0;
      lvl_q    <= '0;
      adj_q    <= '0;
    end else begin
      state_q  <= state_d;
      commas_q <= commas_d;
      good_q   <= good_d;
      lvl_q    <= lvl_d;
      adj_q    <= adj_d;
    end
  end

endmodule

// File: rtl/lane_sync_fsm_props.sv
module lane_sync_fsm_props (
  input logic       clk,
  input logic       rst_n,
  input logic       is_comma,
  input logic       code_err,
  input logic       disp_err,
  input logic [1:0] loss_mode,
  input logic       in_sync,
  input logic [1:0] state
);

  logic bad;
  assign bad = code_err | disp_err;

  p_reset_out_of_sync_r1: assert property (@(posedge clk) !rst_n |=> !in_sync);

  p_wait_for_comma_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd0) && !(is_comma && !bad) |=> (state == 2'd0));

  p_rise_after_good_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_sync) |-> $past(!bad));

  p_single_bad_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_sync && (loss_mode == 2'b01) && bad |=> !in_sync);

  p_good_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
    in_sync && !bad |=> in_sync);

endmodule

bind lane_sync_fsm lane_sync_fsm_props u_props (
  .clk(clk), .rst_n(rst_n), .is_comma(is_comma), .code_err(code_err),
  .disp_err(disp_err), .loss_mode(loss_mode), .in_sync(in_sync), .state(state_q)
);

// File: tb/lane_sync_fsm_test.sv
`timescale 1ns/1ps
module lane_sync_fsm_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       is_comma = 1'b0;
  logic       code_err = 1'b0;
  logic       disp_err = 1'b0;
  logic [1:0] loss_mode = 2'b00;
  logic       in_sync;

  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;

  lane_sync_fsm uut (
    .clk(clk), .rst_n(rst_n), .is_comma(is_comma), .code_err(code_err),
    .disp_err(disp_err), .loss_mode(loss_mode), .in_sync(in_sync)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s in_sync actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic cg(input logic c, input logic ce, input logic de);
    @(negedge clk);
    is_comma = c;
    code_err = ce;
    disp_err = de;
    @(posedge clk);
    #1;
  endtask

  task automatic good();  cg(1'b0, 1'b0, 1'b0); endtask
  task automatic badc();  cg(1'b0, 1'b1, 1'b0); endtask
  task automatic badd();  cg(1'b0, 1'b0, 1'b1); endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst_n = 1'b0;
    loss_mode = m;
    is_comma = 1'b0; code_err = 1'b0; disp_err = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic acquire();
    for (int i = 0; i < 3; i++) begin
      cg(1'b1, 1'b0, 1'b0);
      good();
    end
  endtask

  task automatic t_reset();
    do_reset(2'b00);
    @(negedge clk);
    rst_n = 1'b0;
    #1 chk("R1 during reset", in_sync, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    good();
    chk("R1 after release", in_sync, 1'b0);
  endtask

  task automatic t_los_filter();
    do_reset(2'b00);
    repeat (4) good();
    cg(1'b1, 1'b0, 1'b1);
    good();
    cg(1'b1, 1'b0, 0); good();
    cg(1'b1, 1'b0, 0); good();
    chk("R2 errored comma ignored", in_sync, 1'b0);
    cg(1'b1, 1'b0, 0); good();
    chk("R2 sync after three good commas", in_sync, 1'b1);
  endtask

  task automatic t_acquire();
    do_reset(2'b00);
    cg(1'b1, 0, 0); good();
    cg(1'b1, 0, 0); good();
    chk("R3 two pairs not enough", in_sync, 1'b0);
    cg(1'b1, 0, 0);
    chk("R3 third comma alone", in_sync, 1'b0);
    good();
    chk("R3 sync after third pair", in_sync, 1'b1);
  endtask

  task automatic t_acq_abort();
    do_reset(2'b00);
    cg(1'b1, 0, 0); good();
    cg(1'b1, 0, 0); badc();
    cg(1'b1, 0, 0); good();
    cg(1'b1, 0, 0); good();
    chk("R4 abort restarts count", in_sync, 1'b0);
    cg(1'b1, 0, 0); good();
    chk("R4 fresh three pairs", in_sync, 1'b1);
  endtask

  task automatic t_hyst_drop();
    do_reset(2'b00);
    acquire();
    badc(); badd(); badc();
    chk("R5 R6 three mixed bad keep sync", in_sync, 1'b1);
    badd();
    chk("R6 fourth bad drops", in_sync, 1'b0);
  endtask

  task automatic t_hyst_spread();
    do_reset(2'b00);
    acquire();
    for (int i = 0; i < 3; i++) begin
      badc(); good(); good(); good();
    end
    chk("R6 spread bad keep sync", in_sync, 1'b1);
    badd();
    chk("R6 spread fourth bad drops", in_sync, 1'b0);
  endtask

  task automatic t_hyst_recover();
    do_reset(2'b00);
    acquire();
    badc();
    repeat (4) good();
    badc(); badc(); badc();
    chk("R7 good run lowers level", in_sync, 1'b1);
    badc();
    chk("R7 drop after recovery", in_sync, 1'b0);
  endtask

  task automatic t_mode1();
    do_reset(2'b01);
    acquire();
    repeat (5) good();
    chk("R12 good holds sync", in_sync, 1'b1);
    badd();
    chk("R8 single disparity error drops", in_sync, 1'b0);
  endtask

  task automatic t_mode2();
    do_reset(2'b10);
    acquire();
    badc(); good(); badd(); good();
    chk("R9 isolated bad keeps sync", in_sync, 1'b1);
    badc();
    chk("R9 one bad keeps sync", in_sync, 1'b1);
    badd();
    chk("R9 two adjacent drop", in_sync, 1'b0);
  endtask

  task automatic t_mode3();
    do_reset(2'b11);
    acquire();
    badc(); badd(); good(); badc(); badc();
    chk("R10 two adjacent keep sync", in_sync, 1'b1);
    badd();
    chk("R10 three adjacent drop", in_sync, 1'b0);
  endtask

  task automatic t_switch();
    do_reset(2'b00);
    acquire();
    badc(); badc();
    chk("R11 two bad under hysteresis", in_sync, 1'b1);
    loss_mode = 2'b11;
    badc();
    chk("R11 adjacency carried across switch", in_sync, 1'b0);
    do_reset(2'b00);
    acquire();
    badc(); badc(); badc();
    loss_mode = 2'b10;
    good();
    chk("R11 good under new policy", in_sync, 1'b1);
    loss_mode = 2'b00;
    badc();
    chk("R11 hysteresis level kept", in_sync, 1'b0);
  endtask

  initial begin
    #(8 * 100000);
    total++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    t_reset();
    t_los_filter();
    t_acquire();
    t_acq_abort();
    t_hyst_drop();
    t_hyst_spread();
    t_hyst_recover();
    t_mode1();
    t_mode2();
    t_mode3();
    t_switch();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule